// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block sits beside the read path of an SRAM-style interface. It watches the addresses of accepted read accesses and recognises one ordered chain of six of them. The first five addresses are fixed. The sixth address chooses the command: one value requests a save of the array into nonvolatile storage, and another requests a restore from it.

When the chain completes, the block raises a single-cycle request pulse for the selected command. The logic that carries out the save or restore, and the array itself, lie outside the block. Any write access breaks a partly entered chain.

The read strobe stands for any completed read, whether chip enable or output enable controlled that read. Cycles with no access leave the progress unchanged.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, both pulse outputs are 0. A chain begun before reset does not carry over.
- R2: The five leading read addresses must arrive in exactly this order: 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F.
- R3: If a read at 0x8FC0 follows the five leading reads, `store_req` is 1 in the cycle after that read is accepted.
- R4: If a read at 0x4C63 follows the five leading reads, `recall_req` is 1 in the cycle after that read is accepted.
- R5: Each request pulse is high for exactly one clock cycle, even when further reads follow back to back.
- R6: A read whose address is not the next expected one discards the progress. If that read is at 0x4E38, it counts as the first step of a new chain. Otherwise the detector returns to idle.
- R7: An asserted `wr_valid` returns the detector to idle. If a read is strobed in the same cycle, it is ignored and no pulse follows.
- R8: After a pulse the detector is idle, so a lone read at 0x8FC0 or 0x4C63 issues nothing.
- R9: Cycles with neither strobe asserted neither advance nor clear the progress.
- R10: `store_req` and `recall_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_valid | input | 1 | A read access is accepted this cycle |
| rd_addr | input | ADDR_W (16) | Address of the accepted read |
| wr_valid | input | 1 | A write access is accepted this cycle |
| store_req | output | 1 | One-cycle request to save to nonvolatile storage |
| recall_req | output | 1 | One-cycle request to restore from nonvolatile storage |

## Verification
The bench targets restart handling. A design that returned only to idle on a stray 0x4E38 would miss the chain that begins there. A design that never cleared on a mismatch would fire on an interrupted chain. The bench also drives a write in the same cycle as the sixth read: a design that gives the read priority would issue a request that should have been cancelled. Further tests cover idle gaps inside a chain, the sixth-key addresses arriving when the detector is idle, and back-to-back reads after a pulse. These catch designs that clear the progress on idle cycles, designs that fail to return to idle after a command, and pulses that last longer than one cycle.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

  localparam int unsigned KEY_W      = 16;
  localparam int unsigned PREFIX_LEN = 5;
  localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [KEY_W-1:0] key_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  localparam key_t STORE_KEY  = 16'h8FC0;
  localparam key_t RECALL_KEY = 16'h4C63;

  // Leading keys; the order is the order a host must present them
  function automatic key_t prefix_key(input int unsigned idx);
    case (idx)
      0:       return 16'h4E38;
      1:       return 16'hB1C7;
      2:       return 16'h83E0;
      3:       return 16'h7C1F;
      4:       return 16'h703F;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/nvcmd_key_match.sv
module nvcmd_key_match
  import nvcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [PREFIX_LEN-1:0] prefix_hit,
  output logic                  store_hit,
  output logic                  recall_hit
);

  // One comparator per leading key
  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
    assign prefix_hit[g] = (addr == ADDR_W'(prefix_key(g)));
  end

  assign store_hit  = (addr == ADDR_W'(STORE_KEY));
  assign recall_hit = (addr == ADDR_W'(RECALL_KEY));

endmodule

// File: rtl/nvcmd_step_tracker.sv
module nvcmd_step_tracker
  import nvcmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_valid,
  input  logic                  wr_valid,
  input  logic [PREFIX_LEN-1:0] prefix_hit,
  input  logic                  store_hit,
  input  logic                  recall_hit,
  output logic [STEP_W-1:0]     step_q,
  output cmd_e                  cmd_next
);

  logic [STEP_W-1:0] step_d;
  logic              expect_hit;
  logic              at_final;
  logic [STEP_W-1:0] restart_step;

  assign at_final     = (step_q == STEP_W'(PREFIX_LEN));
  assign restart_step = prefix_hit[0] ? STEP_W'(1) : '0;

  always_comb begin
    expect_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == STEP_W'(i)) expect_hit = prefix_hit[i];
    end
  end

  always_comb begin
    step_d   = step_q;
    cmd_next = CMD_NONE;
    if (wr_valid) begin
      step_d = '0;
    end else if (rd_valid) begin
      if (at_final) begin
        if (store_hit) begin
          cmd_next = CMD_STORE;
          step_d   = '0;
        end else if (recall_hit) begin
          cmd_next = CMD_RECALL;
          step_d   = '0;
        end else begin
          step_d = restart_step;
        end
      end else if (expect_hit) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = restart_step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    step_q <= STEP_W'(PREFIX_LEN)); // R2
  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> step_q == '0); // R7
  AST_RESTART_KEY: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !wr_valid && prefix_hit[0]) |=> step_q == STEP_W'(1)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && !wr_valid) |=> $stable(step_q)); // R9

endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvcmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_valid,
  output logic              store_req,
  output logic              recall_req
);

  logic [PREFIX_LEN-1:0] prefix_hit;
  logic                  store_hit;
  logic                  recall_hit;
  logic [STEP_W-1:0]     step_q;
  cmd_e                  cmd_next;

  nvcmd_key_match #(.ADDR_W(ADDR_W)) u_match (
    .addr       (rd_addr),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit)
  );

  nvcmd_step_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .rd_valid   (rd_valid),
    .wr_valid   (wr_valid),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit),
    .step_q     (step_q),
    .cmd_next   (cmd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= (cmd_next == CMD_STORE);
      recall_req <= (cmd_next == CMD_RECALL);
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req)); // R10
  AST_STORE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req); // R5
  AST_RECALL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req); // R5
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> step_q == '0); // R8
  AST_STORE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(rd_valid && !wr_valid && rd_addr == ADDR_W'(STORE_KEY))); // R3
  AST_RECALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> $past(rd_valid && !wr_valid && rd_addr == ADDR_W'(RECALL_KEY))); // R4

endmodule

// File: tb/nvcmd_seq_detect_test.sv
`timescale 1ns/1ps
module nvcmd_seq_detect_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        wr_valid = 1'b0;
  logic        store_req;
  logic        recall_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nvcmd_seq_detect uut (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .store_req(store_req), .recall_req(recall_req)
  );

  // Vector: {kind[1:0], addr[15:0], expect[1:0]}
  // kind: 0 idle, 1 read, 2 write, 3 read and write together
  // expect: {recall_req, store_req} one cycle after the access
  localparam int NV = 61;
  localparam logic [19:0] VEC [NV] = '{
    // R2 R3 complete save chain
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},{2'd1,16'h8FC0,2'd1},
    // R4 complete restore chain
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},{2'd1,16'h4C63,2'd2},
    // R8 lone final key after a command
    {2'd1,16'h4C63,2'd0},
    // R6 stray address mid chain
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd1,16'h0000,2'd0},{2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},
    {2'd1,16'h8FC0,2'd0},
    // R6 first key restarts the chain
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h4E38,2'd0},
    {2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},{2'd1,16'h7C1F,2'd0},
    {2'd1,16'h703F,2'd0},{2'd1,16'h8FC0,2'd1},
    // R7 write aborts
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd2,16'h7C1F,2'd0},{2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},
    {2'd1,16'h8FC0,2'd0},
    // R7 write in same cycle as final read, then lone final read
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},{2'd3,16'h8FC0,2'd0},
    {2'd1,16'h8FC0,2'd0},
    // R9 idle gaps inside a chain
    {2'd1,16'h4E38,2'd0},{2'd0,16'h0000,2'd0},{2'd1,16'hB1C7,2'd0},
    {2'd1,16'h83E0,2'd0},{2'd0,16'h0000,2'd0},{2'd1,16'h7C1F,2'd0},
    {2'd1,16'h703F,2'd0},{2'd1,16'h4C63,2'd2},
    // R6 first key in the final slot starts over
    {2'd1,16'h4E38,2'd0},{2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},
    {2'd1,16'h7C1F,2'd0},{2'd1,16'h703F,2'd0},{2'd1,16'h4E38,2'd0},
    {2'd1,16'hB1C7,2'd0},{2'd1,16'h83E0,2'd0},{2'd1,16'h7C1F,2'd0},
    {2'd1,16'h703F,2'd0},{2'd1,16'h8FC0,2'd1}
  };

  task automatic chk(input string req, input logic [1:0] exp);
    logic [1:0] act;
    act = {recall_req, store_req};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual={recall,store}=%b expected=%b", req, act, exp);
    end
  endtask

  // One access, then one idle cycle; check lands after the output register
  task automatic access(input logic [1:0] kind, input logic [15:0] a);
    @(negedge clk);
    rd_valid = kind[0];
    wr_valid = kind[1];
    rd_addr  = a;
    @(negedge clk);
    rd_valid = 1'b0;
    wr_valid = 1'b0;
  endtask

  task automatic burst_read(input logic [15:0] a);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = a;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 outputs low while reset is held
    repeat (3) @(negedge clk);
    chk("R1 during reset", 2'b00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 2'b00);

    // Table walk: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19:18], VEC[i][17:2]);
      chk($sformatf("table[%0d] R2 R3 R4 R6 R7 R8 R9 R10", i), VEC[i][1:0]);
    end

    // R5 back-to-back reads, pulse lasts one cycle
    burst_read(16'h4E38); burst_read(16'hB1C7); burst_read(16'h83E0);
    burst_read(16'h7C1F); burst_read(16'h703F); burst_read(16'h8FC0);
    burst_read(16'h1111);
    chk("R5 store pulse high", 2'b01);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R5 store pulse dropped", 2'b00);
    @(negedge clk);
    chk("R5 stays low", 2'b00);

    // R5 same for restore, final read repeated
    burst_read(16'h4E38); burst_read(16'hB1C7); burst_read(16'h83E0);
    burst_read(16'h7C1F); burst_read(16'h703F); burst_read(16'h4C63);
    burst_read(16'h4C63);
    chk("R5 recall pulse high", 2'b10);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R5 repeated final key ignored (R8)", 2'b00);

    // R1 reset mid chain discards progress
    access(2'd1, 16'h4E38); access(2'd1, 16'hB1C7); access(2'd1, 16'h83E0);
    access(2'd1, 16'h7C1F); access(2'd1, 16'h703F);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(2'd1, 16'h8FC0);
    chk("R1 chain lost across reset", 2'b00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule